// File: doc/BRIEF.md
# Streaming Binary 3x3 Convolution Stage with Sign Normalisation

This block is one convolution stage of a binarized neural network. Each input feature map is square, W pixels on a side. It arrives one row per cycle as a packed word in which bit c holds the pixel of column c. Bit 1 stands for +1 and bit 0 stands for -1. The row width W is chosen at run time from 8, 16 or 32. Two line registers hold the previous rows. When a new row arrives, the stage convolves every column of the row before it in parallel, using a 3x3 binary kernel. Kernel taps that fall outside the map are treated as zero, so a tap's value can be -1, 0 or +1 while pixels stay one bit wide.

The column results are added into an integer accumulator array that holds one entry per output pixel. Each input map uses the kernel slot that matches its index. After the last map, every accumulated value x passes through a sign test of k·x + h, where k and h are 16-bit signed coefficients held in registers. Only the sign is kept. The stage then emits one packed binary word per output row. It can optionally combine 2x2 blocks of output bits with a logical OR, which halves both dimensions.

Software-side control is a start pulse with three configuration values: the width code, the number of maps minus one, and the pooling enable. It also uses a write port for kernel slots and a write port for the coefficient pair.

Top module: `bconv_stage`

## Requirements
- R1: A tap contributes +1 when the pixel bit equals the kernel bit and -1 otherwise. The kernel bit index is 3·dy+dx, where dy = 0, 1, 2 selects the row above, the same row and the row below, and dx = 0, 1, 2 selects column c-1, c and c+1. Column c of a row is bit c of its word.
- R2: Taps that fall above the first row, below the last row, left of column 0 or right of column W-1 contribute 0 to the sum.
- R3: The sums of all configured maps (cfg_maps_m1+1, from 1 to 16) are added per output pixel. Map m uses the kernel written to slot m.
- R4: Output bit (r,c) is 1 exactly when k·x + h ≥ 0. Here x is the accumulated sum, and k and h are 16-bit two's complement integers.
- R5: With pooling on, output word j has bit i = OR of the bits at rows 2j and 2j+1 and columns 2i and 2i+1. There are W/2 words of W/2 bits each, issued every other cycle.
- R6: Width code 0 selects W=8, code 1 selects 16, and codes 2 and 3 select 32. Each map is W rows long. Input bits at or above W are ignored. Output bits above the used width are 0.
- R7: Within a map, one row is accepted every cycle. After the last row of each map, in_ready is low for exactly one cycle.
- R8: The first output word appears 2 cycles after the last input row is accepted, or 3 cycles with pooling. Without pooling, words follow on consecutive cycles. out_last is high with the final word only.
- R9: After reset, in_ready, out_valid and out_last are 0.
- R10: Each start clears the accumulators, so a run does not depend on earlier runs. Kernel slots and coefficients keep the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle; latches the configuration |
| cfg_wsel | input | 2 | Row width code |
| cfg_maps_m1 | input | 4 | Number of input maps minus one |
| cfg_pool | input | 1 | Enable 2x2 OR pooling |
| wgt_we | input | 1 | Kernel slot write strobe |
| wgt_idx | input | 4 | Kernel slot index (input map number) |
| wgt_bits | input | 9 | 3x3 kernel bits |
| bn_we | input | 1 | Coefficient write strobe |
| bn_k | input | 16 | Scale coefficient k |
| bn_h | input | 16 | Offset coefficient h |
| in_valid | input | 1 | Input row valid |
| in_ready | output | 1 | Stage accepts an input row |
| in_data | input | 32 | Packed input row |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Packed binary output row |
| out_last | output | 1 | Final output word of the run |

## Verification
In the bench, an input row counts as accepted at the clock edge at which in_ready was high. The bench records the cycle number of the last accepted row of the last map. It then requires the first output word exactly 2 cycles later (3 with pooling), with later words 1 or 2 cycles apart. The one-cycle stall after each map is counted at the first row of the next map, while the driver waits for in_ready. Output words are collected at falling edges, in order, and compared against an integer reference of the convolution, the sign test and the pooling. The reference is built from randomly generated rows whose unused high bits are also random.

// File: rtl/bconv_pkg.sv
package bconv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_EMIT  = 2'd3
    } bconv_state_e;

    // Row width for a width code, limited to the built maximum.
    function automatic int row_width(input logic [1:0] sel, input int max_w);
        int w;
        w = (sel >= 2'd2) ? 32 : (8 << sel);
        return (w > max_w) ? max_w : w;
    endfunction

endpackage

// File: rtl/bconv_window.sv
module bconv_window #(
    parameter int MAX_W  = 32,
    parameter int WCNT_W = $clog2(MAX_W) + 1
) (
    input  logic [MAX_W-1:0]      row_top,
    input  logic [MAX_W-1:0]      row_mid,
    input  logic [MAX_W-1:0]      row_bot,
    input  logic                  top_ok,
    input  logic                  bot_ok,
    input  logic [8:0]            kern,
    input  logic [WCNT_W-1:0]     width,
    output logic [MAX_W-1:0][5:0] sums
);

    for (genvar c = 0; c < MAX_W; c++) begin : g_col
        logic [8:0] pix;
        logic [8:0] tap_ok;
        logic [3:0] n_agree;
        logic [3:0] n_valid;
        logic       col_on;

        for (genvar dx = 0; dx < 3; dx++) begin : g_dx
            localparam int CC = c + dx - 1;
            if (CC < 0 || CC >= MAX_W) begin : g_out
                assign pix[dx]     = 1'b0;
                assign pix[3+dx]   = 1'b0;
                assign pix[6+dx]   = 1'b0;
                assign tap_ok[dx]   = 1'b0;
                assign tap_ok[3+dx] = 1'b0;
                assign tap_ok[6+dx] = 1'b0;
            end else begin : g_in
                logic in_row;
                assign in_row       = WCNT_W'(CC) < width;
                assign pix[dx]      = row_top[CC];
                assign pix[3+dx]    = row_mid[CC];
                assign pix[6+dx]    = row_bot[CC];
                assign tap_ok[dx]   = in_row & top_ok;
                assign tap_ok[3+dx] = in_row;
                assign tap_ok[6+dx] = in_row & bot_ok;
            end
        end

        assign col_on  = WCNT_W'(c) < width;
        assign n_agree = 4'($countones(~(pix ^ kern) & tap_ok));
        assign n_valid = 4'($countones(tap_ok));
        // agreeing taps count +1, disagreeing taps -1, padded taps 0
        assign sums[c] = col_on ? (6'({1'b0, n_agree, 1'b0}) - 6'({2'b00, n_valid})) : 6'd0;
    end

endmodule

// File: rtl/bconv_bnsign.sv
module bconv_bnsign #(
    parameter int MAX_W  = 32,
    parameter int ACC_W  = 9,
    parameter int K_W    = 16,
    parameter int WCNT_W = $clog2(MAX_W) + 1
) (
    input  logic [MAX_W-1:0][ACC_W-1:0] acc_row,
    input  logic signed [K_W-1:0]       coef_k,
    input  logic signed [K_W-1:0]       coef_h,
    input  logic [WCNT_W-1:0]           width,
    output logic [MAX_W-1:0]            signs
);

    localparam int P_W = K_W + ACC_W;

    for (genvar c = 0; c < MAX_W; c++) begin : g_col
        logic signed [P_W-1:0] prod;
        logic signed [P_W:0]   y;
        assign prod     = P_W'(coef_k) * P_W'($signed(acc_row[c]));
        assign y        = (P_W+1)'(prod) + (P_W+1)'(coef_h);
        assign signs[c] = (WCNT_W'(c) < width) & ~y[P_W];
    end

endmodule

// File: rtl/bconv_pool.sv
module bconv_pool #(
    parameter int MAX_W = 32
) (
    input  logic [MAX_W-1:0] upper,
    input  logic [MAX_W-1:0] lower,
    output logic [MAX_W-1:0] pooled
);

    localparam int HALF = MAX_W / 2;

    for (genvar j = 0; j < MAX_W; j++) begin : g_bit
        if (j < HALF) begin : g_lo
            assign pooled[j] = upper[2*j] | upper[2*j+1] | lower[2*j] | lower[2*j+1];
        end else begin : g_hi
            assign pooled[j] = 1'b0;
        end
    end

endmodule

// File: rtl/bconv_stage.sv
module bconv_stage
    import bconv_pkg::*;
#(
    parameter int MAX_W    = 32,
    parameter int MAX_MAPS = 16,
    parameter int K_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [1:0]                    cfg_wsel,
    input  logic [$clog2(MAX_MAPS)-1:0]   cfg_maps_m1,
    input  logic                          cfg_pool,
    input  logic                          wgt_we,
    input  logic [$clog2(MAX_MAPS)-1:0]   wgt_idx,
    input  logic [8:0]                    wgt_bits,
    input  logic                          bn_we,
    input  logic [K_W-1:0]                bn_k,
    input  logic [K_W-1:0]                bn_h,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [MAX_W-1:0]              in_data,
    output logic                          out_valid,
    output logic [MAX_W-1:0]              out_data,
    output logic                          out_last
);

    localparam int MAP_W   = $clog2(MAX_MAPS);
    localparam int ROW_W   = $clog2(MAX_W);
    localparam int WCNT_W  = ROW_W + 1;
    localparam int ACC_RAW = $clog2(9 * MAX_MAPS + 1) + 1;
    localparam int ACC_W   = (ACC_RAW < 6) ? 6 : ACC_RAW;

    typedef struct packed {
        bconv_state_e          st;
        logic [ROW_W-1:0]      row;
        logic [MAP_W-1:0]      map;
        logic [WCNT_W-1:0]     width;
        logic [MAP_W-1:0]      maps_m1;
        logic                  pool;
        logic [MAX_W-1:0]      lb_top;
        logic [MAX_W-1:0]      lb_mid;
        logic [MAX_W-1:0]      sign_prev;
        logic signed [K_W-1:0] k;
        logic signed [K_W-1:0] h;
        logic                  ov;
        logic [MAX_W-1:0]      od;
        logic                  ol;
    } ctl_t;

    ctl_t                         ctl_d, ctl_q;
    logic [MAX_W-1:0][ACC_W-1:0]  acc_d [MAX_W];
    logic [MAX_W-1:0][ACC_W-1:0]  acc_q [MAX_W];
    logic [8:0]                   kern_d [MAX_MAPS];
    logic [8:0]                   kern_q [MAX_MAPS];

    logic                         last_row;
    logic [ROW_W-1:0]             tgt_row;
    logic [MAX_W-1:0][5:0]        sums;
    logic [MAX_W-1:0]             signs;
    logic [MAX_W-1:0]             pooled;
    logic                         in_flush;

    assign in_flush = (ctl_q.st == ST_FLUSH);
    assign last_row = ({1'b0, ctl_q.row} == (ctl_q.width - WCNT_W'(1)));
    assign tgt_row  = in_flush ? ROW_W'(ctl_q.width - WCNT_W'(1)) : (ctl_q.row - ROW_W'(1));

    bconv_window #(.MAX_W(MAX_W), .WCNT_W(WCNT_W)) u_window (
        .row_top (ctl_q.lb_top),
        .row_mid (ctl_q.lb_mid),
        .row_bot (in_flush ? '0 : in_data),
        .top_ok  (in_flush || (ctl_q.row >= ROW_W'(2))),
        .bot_ok  (!in_flush),
        .kern    (kern_q[ctl_q.map]),
        .width   (ctl_q.width),
        .sums    (sums)
    );

    bconv_bnsign #(.MAX_W(MAX_W), .ACC_W(ACC_W), .K_W(K_W), .WCNT_W(WCNT_W)) u_bnsign (
        .acc_row (acc_q[ctl_q.row]),
        .coef_k  (ctl_q.k),
        .coef_h  (ctl_q.h),
        .width   (ctl_q.width),
        .signs   (signs)
    );

    bconv_pool #(.MAX_W(MAX_W)) u_pool (
        .upper  (ctl_q.sign_prev),
        .lower  (signs),
        .pooled (pooled)
    );

    always_comb begin
        ctl_d  = ctl_q;
        acc_d  = acc_q;
        kern_d = kern_q;
        ctl_d.ov = 1'b0;
        ctl_d.ol = 1'b0;

        if (wgt_we) begin
            kern_d[wgt_idx] = wgt_bits;
        end
        if (bn_we) begin
            ctl_d.k = bn_k;
            ctl_d.h = bn_h;
        end

        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.st      = ST_LOAD;
                    ctl_d.width   = WCNT_W'(row_width(cfg_wsel, MAX_W));
                    ctl_d.maps_m1 = cfg_maps_m1;
                    ctl_d.pool    = cfg_pool;
                    ctl_d.row     = '0;
                    ctl_d.map     = '0;
                    for (int r = 0; r < MAX_W; r++) begin
                        acc_d[r] = '0;
                    end
                end
            end
            ST_LOAD: begin
                if (in_valid) begin
                    if (ctl_q.row != '0) begin
                        for (int c = 0; c < MAX_W; c++) begin
                            acc_d[tgt_row][c] = acc_q[tgt_row][c] + ACC_W'($signed(sums[c]));
                        end
                    end
                    ctl_d.lb_top = ctl_q.lb_mid;
                    ctl_d.lb_mid = in_data;
                    if (last_row) begin
                        ctl_d.st = ST_FLUSH;
                    end else begin
                        ctl_d.row = ctl_q.row + ROW_W'(1);
                    end
                end
            end
            ST_FLUSH: begin
                for (int c = 0; c < MAX_W; c++) begin
                    acc_d[tgt_row][c] = acc_q[tgt_row][c] + ACC_W'($signed(sums[c]));
                end
                ctl_d.row = '0;
                if (ctl_q.map == ctl_q.maps_m1) begin
                    ctl_d.st = ST_EMIT;
                end else begin
                    ctl_d.map = ctl_q.map + MAP_W'(1);
                    ctl_d.st  = ST_LOAD;
                end
            end
            ST_EMIT: begin
                if (ctl_q.pool) begin
                    if (!ctl_q.row[0]) begin
                        ctl_d.sign_prev = signs;
                    end else begin
                        ctl_d.ov = 1'b1;
                        ctl_d.od = pooled;
                        ctl_d.ol = last_row;
                    end
                end else begin
                    ctl_d.ov = 1'b1;
                    ctl_d.od = signs;
                    ctl_d.ol = last_row;
                end
                if (last_row) begin
                    ctl_d.st = ST_IDLE;
                end else begin
                    ctl_d.row = ctl_q.row + ROW_W'(1);
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int r = 0; r < MAX_W; r++) begin
                acc_q[r] <= '0;
            end
            for (int m = 0; m < MAX_MAPS; m++) begin
                kern_q[m] <= '0;
            end
        end else begin
            ctl_q  <= ctl_d;
            acc_q  <= acc_d;
            kern_q <= kern_d;
        end
    end

    assign in_ready  = (ctl_q.st == ST_LOAD);
    assign out_valid = ctl_q.ov;
    assign out_data  = ctl_q.od;
    assign out_last  = ctl_q.ol;

    AST_FLUSH_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && last_row) |=> !in_ready) else $error("flush gap missing"); // R7

    AST_STREAM_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !last_row) |=> in_ready) else $error("stall inside a map"); // R7

    AST_POOL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ctl_q.pool) |=> !out_valid) else $error("pooled words back to back"); // R5

    AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid) else $error("last without valid"); // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_data >> ctl_q.width) == '0)) else $error("bits above width set"); // R6

    AST_NO_INPUT_WHILE_EMIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready) else $error("ready during output"); // R8

endmodule

// File: tb/bconv_stage_tb.sv
module bconv_stage_tb_top;

    localparam int MAX_W    = 32;
    localparam int MAX_MAPS = 16;
    localparam int NCASE    = 8;
    localparam int WDOG     = 150000;

    typedef struct packed {
        logic [1:0]  wsel;
        logic [3:0]  mm1;
        logic        pool;
        logic [15:0] k;
        logic [15:0] h;
        logic [31:0] seed;
    } case_t;

    // wsel, maps-1, pool, k, h, seed
    localparam case_t CASES [NCASE] = '{
        '{2'd0, 4'd0,  1'b0, 16'h0001, 16'h0000, 32'h1234_5678},
        '{2'd1, 4'd2,  1'b1, 16'h0003, 16'hFFFB, 32'h0BAD_F00D},
        '{2'd2, 4'd3,  1'b0, 16'hFFFE, 16'h0004, 32'hCAFE_0001},
        '{2'd2, 4'd0,  1'b1, 16'h0001, 16'h0001, 32'h7777_1111},
        '{2'd0, 4'd15, 1'b0, 16'h0005, 16'hFFF9, 32'h2468_ACE0},
        '{2'd1, 4'd1,  1'b0, 16'h0000, 16'h0000, 32'h1357_9BDF},
        '{2'd1, 4'd1,  1'b1, 16'h0000, 16'hFFFF, 32'h5555_AAAA},
        '{2'd3, 4'd1,  1'b0, 16'h0002, 16'hFFFF, 32'h0F0F_3C3C}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  cfg_wsel = '0;
    logic [3:0]  cfg_maps_m1 = '0;
    logic        cfg_pool = 1'b0;
    logic        wgt_we = 1'b0;
    logic [3:0]  wgt_idx = '0;
    logic [8:0]  wgt_bits = '0;
    logic        bn_we = 1'b0;
    logic [15:0] bn_k = '0;
    logic [15:0] bn_h = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_last;

    always #5 clk = ~clk;

    bconv_stage #(.MAX_W(MAX_W), .MAX_MAPS(MAX_MAPS), .K_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_wsel(cfg_wsel), .cfg_maps_m1(cfg_maps_m1), .cfg_pool(cfg_pool),
        .wgt_we(wgt_we), .wgt_idx(wgt_idx), .wgt_bits(wgt_bits),
        .bn_we(bn_we), .bn_k(bn_k), .bn_h(bn_h),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    logic [31:0] rng;

    logic [31:0] pix [MAX_MAPS][MAX_W];
    logic [8:0]  wts [MAX_MAPS];
    logic [31:0] exp_w [MAX_W];
    logic [31:0] got_w [MAX_W];
    int          got_c [MAX_W];
    int          n_got;
    int          last_acc;
    int          stall_err;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WDOG) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog: run hung, actual cycle %0d expected below %0d", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    function automatic int wid(input logic [1:0] sel);
        return (sel >= 2'd2) ? 32 : (8 << sel);
    endfunction

    // Reference: convolution with zero padding, sum over maps, sign test, pooling.
    task automatic build_expect(input case_t cs);
        int w;
        bit sg [MAX_W][MAX_W];
        w = wid(cs.wsel);
        for (int r = 0; r < w; r++) begin
            for (int c = 0; c < w; c++) begin
                int s;
                longint y;
                s = 0;
                for (int m = 0; m <= int'(cs.mm1); m++) begin
                    for (int dy = 0; dy < 3; dy++) begin
                        for (int dx = 0; dx < 3; dx++) begin
                            int rr;
                            int cc;
                            rr = r + dy - 1;
                            cc = c + dx - 1;
                            if (rr >= 0 && rr < w && cc >= 0 && cc < w) begin
                                s += (pix[m][rr][cc] == wts[m][3*dy+dx]) ? 1 : -1;
                            end
                        end
                    end
                end
                y = longint'($signed(cs.k)) * s + longint'($signed(cs.h));
                sg[r][c] = (y >= 0);
            end
        end
        for (int i = 0; i < MAX_W; i++) exp_w[i] = '0;
        if (cs.pool) begin
            for (int j = 0; j < w/2; j++) begin
                for (int i = 0; i < w/2; i++) begin
                    exp_w[j][i] = sg[2*j][2*i] | sg[2*j][2*i+1] | sg[2*j+1][2*i] | sg[2*j+1][2*i+1];
                end
            end
        end else begin
            for (int r = 0; r < w; r++) begin
                for (int c = 0; c < w; c++) exp_w[r][c] = sg[r][c];
            end
        end
    endtask

    task automatic send(input logic [31:0] word, output int stalls);
        stalls = 0;
        @(negedge clk);
        while (!in_ready) begin
            in_valid = 1'b0;
            stalls++;
            @(negedge clk);
        end
        in_valid = 1'b1;
        in_data  = word;
        last_acc = cyc + 1;
    endtask

    task automatic drive(input case_t cs);
        int w;
        int st;
        w = wid(cs.wsel);
        stall_err = 0;
        for (int m = 0; m <= int'(cs.mm1); m++) begin
            for (int r = 0; r < w; r++) begin
                send(pix[m][r], st);
                if (st != ((m > 0 && r == 0) ? 1 : 0)) stall_err++;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic collect();
        n_got = 0;
        while (cyc < WDOG) begin
            @(negedge clk);
            if (out_valid) begin
                if (n_got < MAX_W) begin
                    got_w[n_got] = out_data;
                    got_c[n_got] = cyc;
                end
                n_got++;
                if (out_last) break;
            end
        end
    endtask

    task automatic run_case(input int idx, input case_t cs, input bit load_prog);
        int w;
        int n_exp;
        w = wid(cs.wsel);
        rng = cs.seed;
        for (int m = 0; m <= int'(cs.mm1); m++) begin
            rng = nxt(rng);
            wts[m] = rng[8:0];
            for (int r = 0; r < w; r++) begin
                rng = nxt(rng);
                pix[m][r] = rng;
            end
        end
        build_expect(cs);
        if (load_prog) begin
            for (int m = 0; m <= int'(cs.mm1); m++) begin
                @(negedge clk);
                wgt_we = 1'b1; wgt_idx = 4'(m); wgt_bits = wts[m];
            end
            @(negedge clk);
            wgt_we = 1'b0;
            bn_we = 1'b1; bn_k = cs.k; bn_h = cs.h;
            @(negedge clk);
            bn_we = 1'b0;
        end
        @(negedge clk);
        cfg_wsel = cs.wsel; cfg_maps_m1 = cs.mm1; cfg_pool = cs.pool; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        fork
            drive(cs);
            collect();
        join

        n_exp = cs.pool ? w/2 : w;
        chk(n_got == n_exp, "R5 R6 R8", $sformatf("case %0d word count", idx), 64'(n_got), 64'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++) begin
            chk(got_w[i] == exp_w[i], "R1 R2 R3 R4 R5 R6",
                $sformatf("case %0d word %0d", idx, i), 64'(got_w[i]), 64'(exp_w[i]));
        end
        chk(stall_err == 0, "R7", $sformatf("case %0d ready stalls", idx), 64'(stall_err), 64'd0);
        if (n_got > 0) begin
            chk(got_c[0] - last_acc == 2 + int'(cs.pool), "R8",
                $sformatf("case %0d first word latency", idx),
                64'(got_c[0] - last_acc), 64'(2 + int'(cs.pool)));
        end
        for (int i = 1; i < n_exp && i < n_got; i++) begin
            chk(got_c[i] - got_c[i-1] == (cs.pool ? 2 : 1), "R5 R8",
                $sformatf("case %0d word %0d spacing", idx, i),
                64'(got_c[i] - got_c[i-1]), 64'(cs.pool ? 2 : 1));
        end
        @(negedge clk);
        chk(!out_valid && !out_last, "R8", $sformatf("case %0d quiet after last", idx),
            64'({out_valid, out_last}), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(in_ready == 1'b0, "R9", "in_ready in reset", 64'(in_ready), 64'd0);
        chk(out_valid == 1'b0 && out_last == 1'b0, "R9", "outputs in reset",
            64'({out_valid, out_last}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b0, "R9", "in_ready idle after reset", 64'(in_ready), 64'd0);

        for (int t = 0; t < NCASE; t++) begin
            run_case(t, CASES[t], 1'b1);
        end

        // R10: rerun without reloading. This fails if accumulators carry over
        // or if the kernel slots and coefficients were lost.
        run_case(100, CASES[7], 1'b0);
        chk(n_got == wid(CASES[7].wsel), "R10", "rerun word count", 64'(n_got), 64'(wid(CASES[7].wsel)));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule